// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. Three sources feed it: one asynchronous external pin, on which a high-to-low transition is the event, and two timer overflow pulses. It keeps one 8-bit control register. That register holds a global enable, one enable per source and one request flag per source. The core reads and writes the register over a plain write-strobe and read-data port.

When the global enable is set, a source is both flagged and enabled, the stack has room and the core signals an instruction boundary, the block takes the highest-priority request. On the next cycle it raises a one-cycle acknowledge together with a vector address. In the same step it clears that source's flag and the global enable. A return-from-interrupt strobe sets the global enable again. Software may also set the global enable inside a handler to allow nesting. While the core is halted, any new hardware event raises a one-cycle wake-up request.

Top module: `prio_irq_ctrl`

## Requirements
- R1: The read data shows the global enable at bit 0, the external, timer0 and timer1 enables at bits 1, 2 and 3, and the external, timer0 and timer1 request flags at bits 4, 5 and 6. Bit 7 always reads 0. A register write is visible on the read data after the clock edge that captures it.
- R2: A falling edge on the external pin sets the external flag. The flag is visible SYNC_STAGES+1 clock edges after the pin goes low. A rising edge sets nothing.
- R3: A timer overflow pulse sets that timer's flag at the next edge, whether or not its enable bit is set.
- R4: Fixed priority, highest first: external, then timer0, then timer1. Their vectors are 0x04, 0x08 and 0x0C.
- R5: A request is taken only when the global enable, the source enable and its flag are all 1, the instruction-boundary input is high and the stack-full input is low. The acknowledge appears one cycle after the edge at which these conditions hold.
- R6: In the cycle the acknowledge is high, the read data already shows the taken source's flag cleared and the global enable cleared. The acknowledge lasts exactly one cycle.
- R7: A return-from-interrupt strobe sets the global enable at the next edge, after which pending requests are serviced in priority order.
- R8: While stack-full is high, no acknowledge is issued and the flag stays set. The request is taken at the first edge after stack-full drops.
- R9: A hardware event and a software write of 0 to the same flag in the same cycle leave the flag at 1.
- R10: With the global enable at 0, events only set flags. Writing the global enable to 1, including inside a handler, lets a pending request be taken.
- R11: While the halted input is high, a hardware event on a source whose flag is 0 raises the wake-up output for one cycle. This happens whatever the enable bits hold. An event on a source whose flag is already 1 raises no wake-up.
- R12: After reset the read data is 0x00 and the acknowledge and wake-up outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ext_irq_i | input | 1 | External interrupt pin, asynchronous, falling-edge event |
| tmr_ovf_i | input | 2 | Timer overflow pulses; bit 0 is timer0 |
| reg_we_i | input | 1 | Control register write strobe |
| reg_wdata_i | input | 8 | Control register write data |
| reg_rdata_o | output | 8 | Control register read data |
| instr_bound_i | input | 1 | Core is at an instruction boundary |
| stack_full_i | input | 1 | Return stack has no free entry |
| reti_i | input | 1 | Return-from-interrupt strobe |
| halted_i | input | 1 | Core is in halt mode |
| ack_o | output | 1 | Interrupt acknowledge, one-cycle pulse |
| vector_o | output | 8 | Vector address, valid with ack_o |
| wake_o | output | 1 | Wake-up request, one-cycle pulse |

## Verification
The bench builds the block with its defaults: one external source, two timers, a two-stage pin synchronizer, an 8-bit register and a vector stride of 4. These values reproduce the exact bit layout and the vectors 0x04, 0x08 and 0x0C, so every register value can be checked as a literal byte. The three-edge pin latency is also exact. Writing all three flags at once drains the full priority chain through repeated return strobes. Setting the same flag by hardware and clearing it by software in one cycle exposes the event-over-clear rule.

// File: rtl/prio_irq_ctrl_pkg.sv
package prio_irq_ctrl_pkg;
  function automatic int unsigned vec_addr(int unsigned idx, int unsigned base,
                                           int unsigned stride);
    return base + (idx + 1) * stride;
  endfunction
endpackage

// File: rtl/irq_edge_sync.sv
module irq_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic fall_o
);
  localparam int unsigned LEN = STAGES + 1;
  logic [LEN-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[LEN-2:0], pin_i};
  end

  // synchronized level low, previous level high
  assign fall_o = !chain_q[LEN-2] && chain_q[LEN-1];
endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int unsigned N     = 3,
  parameter int unsigned IDX_W = 2
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  // lowest index wins
  always_comb begin
    any_o = 1'b0;
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        any_o = 1'b1;
        idx_o = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ctrl_regs.sv
module irq_ctrl_regs #(
  parameter int unsigned N     = 3,
  parameter int unsigned REG_W = 8,
  parameter int unsigned IDX_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [REG_W-1:0] wdata_i,
  input  logic [N-1:0]     hw_set_i,
  input  logic             take_i,
  input  logic [IDX_W-1:0] take_idx_i,
  input  logic             reti_i,
  output logic             gie_o,
  output logic [N-1:0]     en_o,
  output logic [N-1:0]     flag_o,
  output logic [REG_W-1:0] rdata_o
);
  localparam int unsigned EN_LO = 1;
  localparam int unsigned FL_LO = N + 1;
  localparam int unsigned USED  = 2 * N + 1;

  logic         gie_q, gie_d;
  logic [N-1:0] en_q, en_d, flag_q, flag_d, flag_base, clr_mask;

  always_comb begin
    clr_mask = '0;
    if (take_i) clr_mask[take_idx_i] = 1'b1;
    flag_base = we_i ? wdata_i[FL_LO +: N] : flag_q;
    flag_d    = (flag_base & ~clr_mask) | hw_set_i;
    en_d      = we_i ? wdata_i[EN_LO +: N] : en_q;
    gie_d     = we_i ? wdata_i[0] : gie_q;
    if (reti_i) gie_d = 1'b1;
    if (take_i) gie_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gie_q  <= 1'b0;
      en_q   <= '0;
      flag_q <= '0;
    end else begin
      gie_q  <= gie_d;
      en_q   <= en_d;
      flag_q <= flag_d;
    end
  end

  generate
    if (REG_W > USED) begin : g_pad
      logic unused_wbits;
      assign unused_wbits = ^wdata_i[REG_W-1:USED];
    end
  endgenerate

  always_comb begin
    rdata_o              = '0;
    rdata_o[0]           = gie_q;
    rdata_o[EN_LO +: N]  = en_q;
    rdata_o[FL_LO +: N]  = flag_q;
  end

  assign gie_o  = gie_q;
  assign en_o   = en_q;
  assign flag_o = flag_q;
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_ctrl_pkg::*;
#(
  parameter int unsigned NUM_TMR     = 2,
  parameter int unsigned REG_W       = 8,
  parameter int unsigned VEC_W       = 8,
  parameter int unsigned VEC_BASE    = 0,
  parameter int unsigned VEC_STRIDE  = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               ext_irq_i,
  input  logic [NUM_TMR-1:0] tmr_ovf_i,
  input  logic               reg_we_i,
  input  logic [REG_W-1:0]   reg_wdata_i,
  output logic [REG_W-1:0]   reg_rdata_o,
  input  logic               instr_bound_i,
  input  logic               stack_full_i,
  input  logic               reti_i,
  input  logic               halted_i,
  output logic               ack_o,
  output logic [VEC_W-1:0]   vector_o,
  output logic               wake_o
);
  localparam int unsigned NSRC  = NUM_TMR + 1;
  localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

  logic             ext_fall;
  logic [NSRC-1:0]  hw_set, en, flag;
  logic             gie, any_req, take;
  logic [IDX_W-1:0] sel_idx;
  logic [VEC_W-1:0] sel_vec;
  logic             ack_q, wake_q;
  logic [VEC_W-1:0] vec_q;

  irq_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  (ext_irq_i),
    .fall_o (ext_fall)
  );

  assign hw_set = {tmr_ovf_i, ext_fall};

  irq_ctrl_regs #(.N(NSRC), .REG_W(REG_W), .IDX_W(IDX_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (reg_we_i),
    .wdata_i    (reg_wdata_i),
    .hw_set_i   (hw_set),
    .take_i     (take),
    .take_idx_i (sel_idx),
    .reti_i     (reti_i),
    .gie_o      (gie),
    .en_o       (en),
    .flag_o     (flag),
    .rdata_o    (reg_rdata_o)
  );

  irq_prio_pick #(.N(NSRC), .IDX_W(IDX_W)) u_pick (
    .req_i (flag & en),
    .any_o (any_req),
    .idx_o (sel_idx)
  );

  assign take    = gie && any_req && instr_bound_i && !stack_full_i;
  assign sel_vec = VEC_W'(vec_addr(int'(sel_idx), VEC_BASE, VEC_STRIDE));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ack_q  <= 1'b0;
      vec_q  <= '0;
      wake_q <= 1'b0;
    end else begin
      ack_q  <= take;
      if (take) vec_q <= sel_vec;
      // only a newly raised flag wakes the core
      wake_q <= halted_i && |(hw_set & ~flag);
    end
  end

  assign ack_o    = ack_q;
  assign vector_o = vec_q;
  assign wake_o   = wake_q;
endmodule

// File: rtl/prio_irq_ctrl_chk.sv
module prio_irq_ctrl_chk #(
  parameter int unsigned NSRC       = 3,
  parameter int unsigned REG_W      = 8,
  parameter int unsigned VEC_W      = 8,
  parameter int unsigned VEC_BASE   = 0,
  parameter int unsigned VEC_STRIDE = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_we_i,
  input logic [REG_W-1:0] reg_rdata_o,
  input logic             instr_bound_i,
  input logic             stack_full_i,
  input logic             reti_i,
  input logic             halted_i,
  input logic             ack_o,
  input logic [VEC_W-1:0] vector_o,
  input logic             wake_o
);
  logic [REG_W-1:0] rd_prev;
  int unsigned      src_bit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rd_prev <= '0;
    else         rd_prev <= reg_rdata_o;
  end

  always_comb src_bit = NSRC + (int'(vector_o) - VEC_BASE) / VEC_STRIDE;

  // R5: acknowledge follows a boundary with room on the stack and gie set
  a_r5_take_cond: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> $past(instr_bound_i && !stack_full_i && reg_rdata_o[0]));
  // R4: vector names a source that was flagged and enabled
  a_r4_vec_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> (rd_prev[src_bit] && rd_prev[src_bit - NSRC]));
  // R6: single-cycle pulse
  a_r6_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);
  // R6: gie already cleared while acknowledging
  a_r6_gie_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |-> !reg_rdata_o[0]);
  // R8: stack full blocks acknowledge
  a_r8_no_ack_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(stack_full_i) |-> !ack_o);
  // R1: top bit reads 0
  a_r1_pad_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[REG_W-1]);
  // R11: wake only out of halt
  a_r11_wake_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(halted_i));
  // R7: reti without write or take sets gie
  a_r7_reti: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(reti_i) && !$past(reg_we_i) && !ack_o) |-> reg_rdata_o[0]);
endmodule

bind prio_irq_ctrl prio_irq_ctrl_chk #(
  .NSRC(NSRC), .REG_W(REG_W), .VEC_W(VEC_W),
  .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .reg_we_i      (reg_we_i),
  .reg_rdata_o   (reg_rdata_o),
  .instr_bound_i (instr_bound_i),
  .stack_full_i  (stack_full_i),
  .reti_i        (reti_i),
  .halted_i      (halted_i),
  .ack_o         (ack_o),
  .vector_o      (vector_o),
  .wake_o        (wake_o)
);

// File: tb/prio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module prio_irq_ctrl_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       ext_irq_i = 1'b1;
  logic [1:0] tmr_ovf_i = '0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       instr_bound_i = 1'b0;
  logic       stack_full_i = 1'b0;
  logic       reti_i = 1'b0;
  logic       halted_i = 1'b0;
  logic       ack_o;
  logic [7:0] vector_o;
  logic       wake_o;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk_i = ~clk_i;

  prio_irq_ctrl u_prio_irq_ctrl (.*);

  task automatic tick(int n = 1);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    reg_we_i = 1'b1; reg_wdata_i = v;
    tick();
    reg_we_i = 1'b0;
  endtask

  task automatic clean();
    instr_bound_i = 0; stack_full_i = 0; halted_i = 0;
    wr(8'h00);
    tick();
  endtask

  task automatic t_reset();
    chk("R12 rdata", reg_rdata_o, 8'h00);
    chk("R12 ack", ack_o, 0);
    chk("R12 wake", wake_o, 0);
  endtask

  task automatic t_reg();
    wr(8'hFF);
    chk("R1 readback bit7 zero", reg_rdata_o, 8'h7F);
    chk("R5 no ack without boundary", ack_o, 0);
    wr(8'h0A);
    chk("R1 readback", reg_rdata_o, 8'h0A);
    clean();
  endtask

  task automatic t_ext();
    ext_irq_i = 0;
    tick(2);
    chk("R2 not yet", reg_rdata_o[4], 0);
    tick();
    chk("R2 fall sets flag", reg_rdata_o, 8'h10);
    wr(8'h00);
    ext_irq_i = 1;
    tick(4);
    chk("R2 rise ignored", reg_rdata_o, 8'h00);
  endtask

  task automatic t_tmr();
    tmr_ovf_i = 2'b01; tick(); tmr_ovf_i = 0;
    chk("R3 tmr0 flag no enable", reg_rdata_o, 8'h20);
    tmr_ovf_i = 2'b10; tick(); tmr_ovf_i = 0;
    chk("R3 tmr1 flag", reg_rdata_o, 8'h60);
    clean();
  endtask

  task automatic t_prio();
    instr_bound_i = 1;
    wr(8'h7F);
    chk("R5 ack next cycle", ack_o, 0);
    tick();
    chk("R4 ext first ack", ack_o, 1);
    chk("R4 ext vector", vector_o, 8'h04);
    chk("R6 flag and gie cleared", reg_rdata_o, 8'h6E);
    reti_i = 1; tick(); reti_i = 0;
    chk("R6 single pulse", ack_o, 0);
    chk("R7 reti sets gie", reg_rdata_o, 8'h6F);
    tick();
    chk("R4 tmr0 second", vector_o, 8'h08);
    chk("R4 tmr0 ack", ack_o, 1);
    chk("R6 regs after tmr0", reg_rdata_o, 8'h4E);
    reti_i = 1; tick(); reti_i = 0;
    tick();
    chk("R4 tmr1 third", vector_o, 8'h0C);
    chk("R7 drain", reg_rdata_o, 8'h0E);
    clean();
  endtask

  task automatic t_gie_off();
    instr_bound_i = 1;
    wr(8'h04);
    tmr_ovf_i = 2'b01; tick(); tmr_ovf_i = 0;
    tick();
    chk("R10 gie off holds", ack_o, 0);
    chk("R10 flag kept", reg_rdata_o, 8'h24);
    wr(8'h25);
    tick();
    chk("R10 taken after gie", ack_o, 1);
    chk("R10 vector", vector_o, 8'h08);
    clean();
  endtask

  task automatic t_stack();
    instr_bound_i = 1; stack_full_i = 1;
    wr(8'h25);
    tick(2);
    chk("R8 no ack when full", ack_o, 0);
    chk("R8 flag kept", reg_rdata_o, 8'h25);
    stack_full_i = 0;
    tick();
    chk("R8 served after room", ack_o, 1);
    chk("R8 cleared", reg_rdata_o, 8'h04);
    clean();
  endtask

  task automatic t_bound_en();
    wr(8'h25);
    tick(2);
    chk("R5 boundary gates", ack_o, 0);
    instr_bound_i = 1;
    tick();
    chk("R5 boundary ack", ack_o, 1);
    clean();
    instr_bound_i = 1;
    wr(8'h21);
    tick(2);
    chk("R5 disabled source ignored", ack_o, 0);
    chk("R5 disabled flag kept", reg_rdata_o, 8'h21);
    clean();
  endtask

  task automatic t_race();
    reg_we_i = 1; reg_wdata_i = 8'h01; tmr_ovf_i = 2'b10;
    tick();
    reg_we_i = 0; tmr_ovf_i = 0;
    chk("R9 event beats clear", reg_rdata_o, 8'h41);
    clean();
  endtask

  task automatic t_nest();
    instr_bound_i = 1;
    wr(8'h49);
    tick();
    chk("R10 outer vector", vector_o, 8'h0C);
    chk("R10 outer regs", reg_rdata_o, 8'h08);
    wr(8'h2D);
    tick();
    chk("R10 nested ack", ack_o, 1);
    chk("R10 nested vector", vector_o, 8'h08);
    chk("R10 nested regs", reg_rdata_o, 8'h0C);
    clean();
  endtask

  task automatic t_wake();
    halted_i = 1;
    tmr_ovf_i = 2'b01; tick(); tmr_ovf_i = 0;
    chk("R11 wake raised", wake_o, 1);
    tick();
    chk("R11 wake pulse", wake_o, 0);
    tmr_ovf_i = 2'b01; tick(); tmr_ovf_i = 0;
    chk("R11 preset flag no wake", wake_o, 0);
    halted_i = 0;
    tmr_ovf_i = 2'b10; tick(); tmr_ovf_i = 0;
    chk("R11 no wake when running", wake_o, 0);
    clean();
  endtask

  initial begin
    tick(3);
    rst_ni = 1;
    tick();
    t_reset();
    t_reg();
    t_ext();
    t_tmr();
    t_prio();
    t_gie_off();
    t_stack();
    t_bound_en();
    t_race();
    t_nest();
    t_wake();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule